// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital sequencer for a successive-approximation analog-to-digital converter. It picks one of ten inputs: eight regular channels (0 to 7) and two extended channels (8 and 9). It presents a trial code and a channel number to an external comparator and reads back one decision bit each conversion-clock tick. It builds the code one bit at a time, from the most significant bit down, and places the finished code in a byte-addressed result area. The analog comparator, the resistor ladder and any sample-and-hold circuit sit outside the block.

Software controls the block through a small byte bus. The bus has a control byte at address 20, a configuration byte at address 21 and a priority-channel byte at address 22. The result area is at addresses 0 to 19, with channel c at bytes 2c and 2c+1. A conversion starts either when software sets the start flag, or on a falling edge of the external trigger input while the flag is set. Five sequencing modes are offered: one-shot, repeat, single sweep, looping sweep, and looping sweep with an interleaved priority channel. The trigger input passes through three flip-flops, so a falling edge acts on the third rising clock edge after the input drops.

Top module: `adc_seq`

## Requirements
- R1: In 10-bit mode (configuration bit 6 = 1), a comparator that answers "input >= trial" yields the input code. Channel c stores bits 7:0 at byte 2c and bits 9:8 in bits 1:0 of byte 2c+1. This holds for extended channels 8 and 9 as well.
- R2: In 8-bit mode (configuration bit 6 = 0), only trial bits 9:2 are tested and trial bits 1:0 stay 0. Byte 2c receives the 8-bit code (input >> 2), and byte 2c+1 reads 0.
- R3: A conversion keeps busy high for L x D clock cycles. L is 49 (8-bit) or 59 (10-bit) when configuration bit 7 = 0, and 28 or 33 when bit 7 = 1. D is 1, 2 or 4 for control bits 7:6 = 0, 1 or 2.
- R4: Control bits 2:0 select the mode: 0 one-shot, 1 repeat, 2 single sweep, 3 looping sweep, 4 looping sweep with priority channel. In one-shot mode the channel in configuration bits 3:0 is converted once. The start flag (control bit 4) then clears, busy falls, and irq pulses for exactly one cycle.
- R5: Repeat mode converts the selected channel again and again, and the result register always holds the latest completed conversion. Writing the start flag to 0 drops busy at the next clock edge. No irq is raised.
- R6: Single sweep converts channels 0 to N-1 in ascending order once. N = 2, 4, 6 or 8 for configuration bits 5:4 = 0, 1, 2 or 3. Busy then falls, the flag clears, and one irq pulse is given.
- R7: Looping sweep (mode 3) visits channels 0 to N-1 in order and wraps back to 0 with no irq. It runs until software clears the flag.
- R8: Mode 4 interleaves the priority channel (address 22, bits 3:0) after every sweep channel: 0, P, 1, P, and so on. It wraps after N-1, P.
- R9: Control bit 5 drives ref_en. A start request is ignored unless this bit was already 1 before the write and stays 1 in it. An ignored request leaves the flag at 0 and busy low.
- R10: With control bit 3 = 1, writing the flag does not start a conversion. A falling trigger edge starts one while the flag and ref are 1. The flag stays 1 afterwards. Edges are ignored while the flag is 0.
- R11: A trigger edge during a conversion restarts the sequence. If the edge acts on the same edge that would have ended the conversion, the restart wins, that conversion's code is dropped, and no irq is raised.
- R12: Bus writes to the result area have no effect. A channel value above 9 written to configuration bits 3:0 or to the priority byte is ignored, and the old value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| trig_n | input | 1 | External trigger, acts on falling edge |
| cmp_ch | output | 4 | Channel routed to the comparator |
| cmp_trial | output | 10 | Trial code under test |
| cmp_bit | input | 1 | Comparator answer, 1 when input >= trial |
| ref_en | output | 1 | Reference ladder connect |
| busy | output | 1 | A conversion sequence is running |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The end of a conversion and a retriggering trigger edge can land on the same clock edge. The bench provokes this by dropping the trigger exactly L clock cycles after the first drop. Because the trigger path is a fixed three-stage pipeline, the restart then acts on the finishing edge. The bench judges the outcome from busy and irq: busy must stay high for 2L cycles without a gap, and only one irq may appear, at the end of the second conversion.

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
  parameter int NCH       = 10,
  parameter int LEN_LO    = 49,
  parameter int LEN_HI    = 59,
  parameter int LEN_LO_SH = 28,
  parameter int LEN_HI_SH = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       trig_n,
  output logic [3:0] cmp_ch,
  output logic [9:0] cmp_trial,
  input  logic       cmp_bit,
  output logic       ref_en,
  output logic       busy,
  output logic       irq
);
  localparam logic [4:0] A_CTL0 = 5'(2*NCH);
  localparam logic [4:0] A_CTL1 = 5'(2*NCH+1);
  localparam logic [4:0] A_CTL2 = 5'(2*NCH+2);
  localparam logic [3:0] CH_MAX = 4'(NCH-1);

  logic [2:0] mode_q, tsync_q;
  logic       ext_q, go_q, ref_q, r10_q, sh_q, pph_q;
  logic [1:0] div_q, swp_q, dc_q;
  logic [3:0] sel_q, pri_q, ch_q, idx_q;
  logic [5:0] tc_q;
  logic [9:0] sar_q;
  logic [9:0] res_q [NCH];

  wire wr0 = bus_we && bus_addr == A_CTL0;
  wire wr1 = bus_we && bus_addr == A_CTL1;
  wire wr2 = bus_we && bus_addr == A_CTL2;
  wire wgo = bus_wdata[4] & bus_wdata[5] & ref_q;
  wire [2:0] mode_nx = wr0 ? bus_wdata[2:0] : mode_q;

  wire fall  = tsync_q[2] & ~tsync_q[1];
  wire sw_go = wr0 & ~bus_wdata[3] & wgo & ~go_q;
  wire ex_go = ext_q & go_q & ref_q & fall & ~wr0;
  wire start = sw_go | ex_go;
  wire stop  = wr0 & ~wgo;

  wire [1:0] dmax = (div_q == 2'd0) ? 2'd0 : (div_q == 2'd1) ? 2'd1 : 2'd3;
  wire       tick = busy && dc_q == dmax;
  wire [5:0] len  = sh_q ? (r10_q ? 6'(LEN_HI_SH) : 6'(LEN_LO_SH))
                         : (r10_q ? 6'(LEN_HI)    : 6'(LEN_LO));
  wire [5:0] nbits  = r10_q ? 6'd10 : 6'd8;
  wire       in_sar = tc_q >= len - nbits;
  wire [3:0] pos    = 4'(len - 6'd1 - tc_q) + (r10_q ? 4'd0 : 4'd2);
  wire [9:0] mask   = in_sar ? (10'd1 << pos) : 10'd0;
  wire [9:0] sar_nx = cmp_bit ? cmp_trial : sar_q;
  wire       last   = tick && tc_q == len - 6'd1;

  wire [3:0] nsw      = {1'b0, swp_q, 1'b0} + 4'd2;
  wire       idx_wrap = idx_q == nsw - 4'd1;
  wire [3:0] idx_nx   = idx_wrap ? 4'd0 : idx_q + 4'd1;
  wire       fin      = last && (mode_q == 3'd0 || mode_q > 3'd4 || (mode_q == 3'd2 && idx_wrap));

  assign cmp_trial = busy ? (sar_q | mask) : 10'd0;
  assign cmp_ch    = ch_q;
  assign ref_en    = ref_q;

  wire [3:0] ridx = bus_addr[4:1];
  wire [9:0] rsel = res_q[ridx];
  always_comb begin
    bus_rdata = 8'd0;
    if (bus_addr < A_CTL0)       bus_rdata = bus_addr[0] ? {6'd0, rsel[9:8]} : rsel[7:0];
    else if (bus_addr == A_CTL0) bus_rdata = {div_q, ref_q, go_q, ext_q, mode_q};
    else if (bus_addr == A_CTL1) bus_rdata = {sh_q, r10_q, swp_q, sel_q};
    else if (bus_addr == A_CTL2) bus_rdata = {4'd0, pri_q};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {mode_q, ext_q, go_q, ref_q, div_q, sel_q, swp_q, r10_q, sh_q, pri_q} <= '0;
      {busy, irq, tc_q, dc_q, sar_q, ch_q, idx_q, pph_q} <= '0;
      tsync_q <= 3'b111;
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else begin
      tsync_q <= {tsync_q[1:0], trig_n};
      irq     <= fin & ~start & ~stop;
      if (wr0) begin
        mode_q <= bus_wdata[2:0];
        ext_q  <= bus_wdata[3];
        go_q   <= wgo;
        ref_q  <= bus_wdata[5];
        div_q  <= bus_wdata[7:6];
      end else if (fin && !ext_q) go_q <= 1'b0;
      if (wr1) begin
        if (bus_wdata[3:0] <= CH_MAX) sel_q <= bus_wdata[3:0];
        swp_q <= bus_wdata[5:4];
        r10_q <= bus_wdata[6];
        sh_q  <= bus_wdata[7];
      end
      if (wr2 && bus_wdata[3:0] <= CH_MAX) pri_q <= bus_wdata[3:0];

      if (start) dc_q <= 2'd0;
      else if (busy) dc_q <= tick ? 2'd0 : dc_q + 2'd1;

      if (start) begin
        busy  <= 1'b1;
        tc_q  <= 6'd0;
        sar_q <= 10'd0;
        idx_q <= 4'd0;
        pph_q <= 1'b0;
        ch_q  <= (mode_nx < 3'd2) ? sel_q : 4'd0;
      end else if (stop) begin
        busy <= 1'b0;
      end else if (tick) begin
        tc_q <= tc_q + 6'd1;
        if (in_sar) sar_q <= sar_nx;
        if (last) begin
          res_q[ch_q] <= r10_q ? sar_nx : {2'b00, sar_nx[9:2]};
          tc_q  <= 6'd0;
          sar_q <= 10'd0;
          case (mode_q)
            3'd2: if (!idx_wrap) begin idx_q <= idx_nx; ch_q <= idx_nx; end
            3'd3: begin idx_q <= idx_nx; ch_q <= idx_nx; end
            3'd4:
              if (pph_q) begin pph_q <= 1'b0; idx_q <= idx_nx; ch_q <= idx_nx; end
              else begin pph_q <= 1'b1; ch_q <= pri_q; end
            default: ;
          endcase
          if (fin) busy <= 1'b0;
        end
      end
    end
endmodule

module adc_seq_chk #(parameter int NCH = 10) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       irq,
  input logic       ref_en,
  input logic       r10,
  input logic [3:0] cmp_ch,
  input logic [9:0] cmp_trial
);
  a_r9_busy_needs_ref: assert property (@(posedge clk) disable iff (!rst_n) busy |-> ref_en);
  a_r4_irq_when_idle:  assert property (@(posedge clk) disable iff (!rst_n) irq |-> !busy);
  a_r4_irq_one_cycle:  assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  a_r12_channel_legal: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cmp_ch <= 4'(NCH-1));
  a_r2_trial_low_zero: assert property (@(posedge clk) disable iff (!rst_n) (busy && !r10) |-> cmp_trial[1:0] == 2'b00);
endmodule

bind adc_seq adc_seq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .ref_en(ref_en),
  .r10(r10_q), .cmp_ch(cmp_ch), .cmp_trial(cmp_trial)
);

// File: tb/adc_seq_tb_top.sv
`timescale 1ns/1ps
module adc_seq_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, trig_n = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] cmp_ch;
  logic [9:0] cmp_trial;
  logic       cmp_bit, ref_en, busy, irq;
  logic [9:0] ain [16];
  int exp_res [10];
  int seq [16];
  int ngrab, nchk = 0, nerr = 0, irq_cnt = 0;

  adc_seq dut_i (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_n(trig_n), .cmp_ch(cmp_ch),
    .cmp_trial(cmp_trial), .cmp_bit(cmp_bit), .ref_en(ref_en), .busy(busy), .irq(irq));

  assign cmp_bit = ain[cmp_ch] >= cmp_trial;
  always #2.5 clk = ~clk;
  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  function automatic int elen(bit r10, bit sh);
    return sh ? (r10 ? 33 : 28) : (r10 ? 59 : 49);
  endfunction
  function automatic int ediv(int dv);
    return dv == 0 ? 1 : (dv == 1 ? 2 : 4);
  endfunction
  function automatic int estore(int v, bit r10);
    return r10 ? v : (v >> 2);
  endfunction
  function automatic logic [7:0] c0(int mode, bit ext, bit go, bit rf, int dv);
    return 8'((dv << 6) | (rf << 5) | (go << 4) | (ext << 3) | mode);
  endfunction
  function automatic logic [7:0] c1(int ch, int swp, bit r10, bit sh);
    return 8'((sh << 7) | (r10 << 6) | (swp << 4) | ch);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask
  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask
  task automatic rd(input int a, output int v);
    bus_addr = 5'(a); #1; v = bus_rdata;
  endtask
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_idle(output int c);
    c = 0;
    while (busy && c < 5000) begin c++; @(negedge clk); end
  endtask
  task automatic check_results(input string req);
    int lo, hi;
    for (int ch = 0; ch < 10; ch++) begin
      rd(2*ch, lo); rd(2*ch+1, hi);
      chk(lo == (exp_res[ch] & 255), req, lo, exp_res[ch] & 255);
      chk(hi == (exp_res[ch] >> 8), req, hi, exp_res[ch] >> 8);
    end
  endtask
  task automatic grab(input int n);
    int last = -1;
    ngrab = 0;
    for (int t = 0; t < 4000 && ngrab < n; t++) begin
      @(negedge clk);
      if (busy && int'(cmp_ch) != last) begin seq[ngrab] = cmp_ch; last = cmp_ch; ngrab++; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int v, c, ic, ch, dv, bsy;
    bit r10, sh;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) ain[i] = 10'd0;
    for (int i = 0; i < 10; i++) exp_res[i] = 0;
    cyc(4); rst_n = 1'b1; cyc(1);
    chk(busy == 0, "R4 reset busy", busy, 0);
    chk(irq == 0, "R4 reset irq", irq, 0);
    chk(ref_en == 0, "R9 reset ref_en", ref_en, 0);
    rd(20, v); chk(v == 0, "R4 reset control", v, 0);

    // R9: start with reference not yet connected
    wr(20, c0(0, 0, 1, 1, 0)); cyc(5);
    chk(busy == 0, "R9 start ignored busy", busy, 0);
    rd(20, v); chk(v[4] == 0, "R9 flag stays clear", v[4], 0);
    chk(ref_en == 1, "R9 ref_en follows bit", ref_en, 1);
    wr(20, c0(0, 0, 1, 0, 0)); cyc(5);
    chk(busy == 0, "R9 start with ref cleared", busy, 0);
    chk(ref_en == 0, "R9 ref_en off", ref_en, 0);
    wr(20, c0(0, 0, 0, 1, 0));

    // R1 R2 R3 R4: one-shot conversions, directed corners then random
    for (int it = 0; it < 24; it++) begin
      ch = $urandom % 10; r10 = 1'($urandom); sh = 1'($urandom); dv = $urandom % 3;
      v = $urandom % 1024;
      if (it == 0) begin ch = 8; v = 1023; r10 = 1; end
      if (it == 1) begin ch = 9; v = 0;    r10 = 1; end
      if (it == 2) begin ch = 0; v = 3;    r10 = 0; end
      if (it == 3) begin ch = 7; v = 1023; r10 = 0; end
      ain[ch] = 10'(v);
      wr(21, c1(ch, 0, r10, sh));
      ic = irq_cnt;
      wr(20, c0(0, 0, 1, 1, dv));
      wait_idle(c);
      chk(c == elen(r10, sh) * ediv(dv), "R3 busy length", c, elen(r10, sh) * ediv(dv));
      cyc(2);
      chk(irq_cnt - ic == 1, "R4 one irq", irq_cnt - ic, 1);
      rd(20, v); chk(v[4] == 0, "R4 flag cleared", v[4], 0);
      exp_res[ch] = estore(ain[ch], r10);
      check_results(r10 ? "R1 result" : "R2 result");
    end

    // R12: result bytes read-only, illegal channel numbers ignored
    wr(0, 8'hFF); wr(1, 8'hFF);
    check_results("R12 result write ignored");
    wr(21, c1(4, 0, 1, 0)); wr(21, c1(12, 0, 1, 0));
    rd(21, v); chk(v[3:0] == 4, "R12 channel above 9 ignored", v[3:0], 4);
    wr(22, 8'd7); wr(22, 8'd14);
    rd(22, v); chk(v == 7, "R12 priority above 9 ignored", v, 7);

    // R6: single sweep over six channels
    for (int i = 0; i < 10; i++) ain[i] = 10'($urandom % 1024);
    wr(21, c1(0, 2, 1, 1));
    ic = irq_cnt;
    wr(20, c0(2, 0, 1, 1, 0));
    wait_idle(c);
    chk(c == 6 * 33, "R6 sweep length", c, 6 * 33);
    cyc(2);
    chk(irq_cnt - ic == 1, "R6 one irq", irq_cnt - ic, 1);
    rd(20, v); chk(v[4] == 0, "R6 flag cleared", v[4], 0);
    for (int i = 0; i < 6; i++) exp_res[i] = ain[i];
    check_results("R6 sweep results");

    // R7: looping sweep over four channels, 8-bit
    wr(21, c1(0, 1, 0, 1));
    ic = irq_cnt;
    wr(20, c0(3, 0, 1, 1, 0));
    grab(10);
    chk(ngrab == 10, "R7 sequence length", ngrab, 10);
    for (int i = 0; i < 10; i++) chk(seq[i] == i % 4, "R7 order", seq[i], i % 4);
    chk(busy == 1, "R7 still running", busy, 1);
    wr(20, c0(3, 0, 0, 1, 0));
    chk(busy == 0, "R7 stop", busy, 0);
    chk(irq_cnt == ic, "R7 no irq", irq_cnt - ic, 0);
    for (int i = 0; i < 4; i++) exp_res[i] = estore(ain[i], 0);
    check_results("R7 results");

    // R8: priority channel 7 interleaved into a two-channel sweep
    wr(22, 8'd7);
    wr(21, c1(0, 0, 1, 1));
    wr(20, c0(4, 0, 1, 1, 0));
    grab(8);
    chk(ngrab == 8, "R8 sequence length", ngrab, 8);
    for (int i = 0; i < 8; i++)
      chk(seq[i] == ((i % 2) ? 7 : (i / 2) % 2), "R8 order", seq[i], (i % 2) ? 7 : (i / 2) % 2);
    wr(20, c0(4, 0, 0, 1, 0));
    chk(busy == 0, "R8 stop", busy, 0);
    exp_res[0] = ain[0]; exp_res[1] = ain[1]; exp_res[7] = ain[7];
    check_results("R8 results");

    // R5: repeat mode tracks a changing input
    ain[3] = 10'd100;
    wr(21, c1(3, 0, 1, 0));
    ic = irq_cnt;
    wr(20, c0(1, 0, 1, 1, 1));
    cyc(240);
    chk(busy == 1, "R5 still converting", busy, 1);
    ain[3] = 10'd777;
    cyc(118 * 3 + 10);
    rd(6, v); chk(v == (777 & 255), "R5 latest low byte", v, 777 & 255);
    rd(7, v); chk(v == (777 >> 8), "R5 latest high byte", v, 777 >> 8);
    wr(20, c0(1, 0, 0, 1, 1));
    chk(busy == 0, "R5 stop next edge", busy, 0);
    chk(irq_cnt == ic, "R5 no irq", irq_cnt - ic, 0);
    exp_res[3] = 777;

    // R10: external trigger
    ain[5] = 10'd612;
    wr(21, c1(5, 0, 1, 1));
    wr(20, c0(0, 1, 1, 1, 0));
    cyc(10);
    chk(busy == 0, "R10 flag write alone", busy, 0);
    rd(20, v); chk(v[4] == 1, "R10 flag set", v[4], 1);
    ic = irq_cnt; bsy = 0;
    trig_n = 1'b0;
    for (int k = 1; k <= 3 * 33; k++) begin
      @(negedge clk);
      if (busy) bsy++;
      if (k == 5) trig_n = 1'b1;
    end
    chk(bsy == 33, "R10 triggered length", bsy, 33);
    chk(irq_cnt - ic == 1, "R10 one irq", irq_cnt - ic, 1);
    rd(20, v); chk(v[4] == 1, "R10 flag kept", v[4], 1);
    exp_res[5] = 612;
    check_results("R10 result");
    wr(20, c0(0, 1, 0, 1, 0));
    trig_n = 1'b0; cyc(5); trig_n = 1'b1; cyc(5);
    chk(busy == 0, "R10 edge with flag clear", busy, 0);

    // R11: retrigger on the finishing edge
    ain[5] = 10'd45;
    wr(20, c0(0, 1, 1, 1, 0));
    cyc(3);
    ic = irq_cnt; bsy = 0;
    trig_n = 1'b0;
    for (int k = 1; k <= 4 * 33; k++) begin
      @(negedge clk);
      if (busy) bsy++;
      if (k == 5) trig_n = 1'b1;
      if (k == 33) trig_n = 1'b0;
      if (k == 38) trig_n = 1'b1;
    end
    chk(bsy == 66, "R11 busy spans restart", bsy, 66);
    chk(irq_cnt - ic == 1, "R11 single irq", irq_cnt - ic, 1);
    exp_res[5] = 45;
    check_results("R11 result");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule